// File: doc/BRIEF.md
# Serial Avionics Word Receiver with Label-Bit Filter

This block receives 32-bit words from a two-level return-to-zero avionics data line. Two digital inputs from an external comparator stage carry the line state. One marks a positive mark, the other a negative mark. Both low means the line is idle.

A sample strobe is derived from the system clock by a divider of 10 or 80. The receiver takes one sample per strobe, and a bit lasts ten samples. A mark that persists long enough becomes a data bit. Bits are packed LSB-first: the first bit on the line lands in word bit 0. A long idle period marks the end of a word.

Two kinds of framed word are dropped without any output:
- a word in which the line showed an illegal state;
- a word whose two selector bits do not match a programmed pair, when that filter is enabled.

A self-test input, active low, switches the receiver to a local transmitter's mark pair in place of the external line.

Top module: `arinc_rx_sdi`

## Requirements
- R1: The first bit received is stored in `word_out[0]`, and the k-th bit received in `word_out[k-1]`. The line-bit positions 9 and 10 (the selector bits) are therefore `word_out[8]` and `word_out[9]`.
- R2: With `self_test_n`=0 the receiver takes `loop_one`/`loop_zero` and ignores `line_one`/`line_zero`. With `self_test_n`=1 it takes the line pins and ignores the loop pins.
- R3: With `dec_en`=1 a framed word is accepted only when `word_out[8]` would equal `match_b9` and `word_out[9]` would equal `match_b10`. Any other framed word is dropped: no strobe, and the output is unchanged.
- R4: With `dec_en`=0 every correctly framed 32-bit word is accepted, whatever its selector bits.
- R5: The sample strobe comes every 10 clocks when `slow_sel`=0 and every 80 clocks when `slow_sel`=1. A word timed for one rate is not received at the other.
- R6: A mark is a data bit once it has held for 3 consecutive samples. A mark held for only 2 samples is ignored. A positive mark (one=1, zero=0) is a 1 and a negative mark (one=0, zero=1) is a 0.
- R7: A sample with one=1 and zero=1 at any point in a word causes the word to be rejected.
- R8: A positive mark followed directly by a negative mark, or the reverse, with no idle sample between them, causes the word to be rejected.
- R9: Idle lasting 20 samples (two bit times) ends a word. Fewer than 32 bits before such a gap are discarded, and the next word starts clean.
- R10: Each accepted word raises `word_valid` for exactly one clock. `word_out` changes only in that cycle and otherwise holds the last accepted word.
- R11: While `rst_n` is low and after its release, `word_valid` is 0 and `word_out` is 0, and any partial word is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_one | input | 1 | External line positive-mark indication |
| line_zero | input | 1 | External line negative-mark indication |
| loop_one | input | 1 | Local transmitter positive-mark output |
| loop_zero | input | 1 | Local transmitter negative-mark output |
| self_test_n | input | 1 | 0 selects the loop inputs, 1 the external line |
| slow_sel | input | 1 | Sample divider: 0 = /10, 1 = /80 |
| dec_en | input | 1 | Enables the selector-bit filter |
| match_b9 | input | 1 | Required value of line bit 9 |
| match_b10 | input | 1 | Required value of line bit 10 |
| word_out | output | 32 | Last accepted word, first bit received at index 0 |
| word_valid | output | 1 | One-clock strobe on acceptance |

## Verification
A wrong bit counter or shift register does not show at the ports until the word ends. It then shows as a missing strobe, an extra strobe, or a word with rotated or shifted bits, roughly one word time (about 32 bit times) after the fault. A sticky error flag that fails to clear after the idle gap shows as a lost next word. A flag that fails to set lets a malformed word through with a strobe. A wrong sample divider lets no word through at all. Each stimulus is therefore followed by a full idle gap, and the strobe count and the held word are both compared against the expected values.

// File: rtl/arinc_rx_sdi.sv
module arinc_rx_sdi #(
  parameter int WORD_BITS  = 32,
  parameter int OVERSAMPLE = 10,
  parameter int MIN_RUN    = 3,
  parameter int GAP_BITS   = 2,
  parameter int FAST_DIV   = 10,
  parameter int SLOW_DIV   = 80,
  parameter int ADDR_LSB   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_one,
  input  logic                 line_zero,
  input  logic                 loop_one,
  input  logic                 loop_zero,
  input  logic                 self_test_n,
  input  logic                 slow_sel,
  input  logic                 dec_en,
  input  logic                 match_b9,
  input  logic                 match_b10,
  output logic [WORD_BITS-1:0] word_out,
  output logic                 word_valid
);
  localparam int GAP_SAMPLES = GAP_BITS * OVERSAMPLE;
  localparam int MAX_DIV     = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int DIV_W       = $clog2(MAX_DIV + 1);
  localparam int RUN_W       = $clog2(GAP_SAMPLES + 1);
  localparam int CNT_W       = $clog2(WORD_BITS + 1);

  localparam logic [1:0] LV_IDLE = 2'b00;
  localparam logic [1:0] LV_BAD  = 2'b11;

  logic [DIV_W-1:0]     div_cnt;
  logic [DIV_W-1:0]     div_lim;
  logic                 tick;
  logic [1:0]           cur, prev_lvl;
  logic [RUN_W-1:0]     run_cnt, run_next;
  logic [CNT_W-1:0]     bit_cnt;
  logic [WORD_BITS-1:0] shreg, shift_nxt;
  logic                 err;
  logic                 is_mark, prev_mark, take, flip, bad, gap;
  logic                 err_now, last_bit, addr_ok, accept;

  assign div_lim = slow_sel ? DIV_W'(SLOW_DIV - 1) : DIV_W'(FAST_DIV - 1);
  assign tick    = (div_cnt >= div_lim);

  assign cur       = self_test_n ? {line_one, line_zero} : {loop_one, loop_zero};
  assign is_mark   = cur[1] ^ cur[0];
  assign prev_mark = prev_lvl[1] ^ prev_lvl[0];

  assign run_next = (cur != prev_lvl) ? RUN_W'(1) :
                    (run_cnt >= RUN_W'(GAP_SAMPLES)) ? run_cnt : run_cnt + RUN_W'(1);

  assign take  = tick && is_mark && (run_next == RUN_W'(MIN_RUN));
  assign flip  = tick && is_mark && prev_mark && (cur != prev_lvl);
  assign bad   = tick && (cur == LV_BAD);
  assign gap   = tick && (cur == LV_IDLE) && (run_next >= RUN_W'(GAP_SAMPLES));

  assign shift_nxt = {cur[1], shreg[WORD_BITS-1:1]};
  assign last_bit  = take && (bit_cnt == CNT_W'(WORD_BITS - 1));
  assign addr_ok   = !dec_en || ((shift_nxt[ADDR_LSB] == match_b9) &&
                                 (shift_nxt[ADDR_LSB+1] == match_b10));
  assign err_now   = bad || flip;
  assign accept    = last_bit && !err && !err_now && addr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lvl <= LV_IDLE;
      run_cnt  <= '0;
    end else if (tick) begin
      prev_lvl <= cur;
      run_cnt  <= run_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
      err     <= 1'b0;
    end else if (gap) begin
      bit_cnt <= '0;
      shreg   <= '0;
      err     <= 1'b0;
    end else begin
      if (err_now) err <= 1'b1;
      if (take) begin
        if (bit_cnt < CNT_W'(WORD_BITS)) begin
          shreg   <= shift_nxt;
          bit_cnt <= bit_cnt + CNT_W'(1);
        end else begin
          err <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= accept;
      if (accept) word_out <= shift_nxt;
    end
  end

  a_r10_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  a_r10_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_out) |-> word_valid);

  a_r3_selector_match: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (!$past(dec_en) ||
      (word_out[ADDR_LSB] == $past(match_b9) && word_out[ADDR_LSB+1] == $past(match_b10))));

  a_r9_full_word: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> ($past(bit_cnt) == CNT_W'(WORD_BITS - 1)));

  a_r7_bad_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cur == LV_BAD) |=> err);

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_BITS));
endmodule

// File: tb/arinc_rx_sdi_bench.sv
module arinc_rx_sdi_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_one = 1'b0, line_zero = 1'b0;
  logic        loop_one = 1'b0, loop_zero = 1'b0;
  logic        self_test_n = 1'b1, slow_sel = 1'b0;
  logic        dec_en = 1'b0, match_b9 = 1'b0, match_b10 = 1'b0;
  logic [31:0] word_out;
  logic        word_valid;

  int checks = 0, errors = 0;
  int vrise = 0, vhigh = 0;
  logic prev_v = 1'b0;
  logic [31:0] lastw = '0;
  logic use_loop = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  arinc_rx_sdi u_arinc_rx_sdi (
    .clk(clk), .rst_n(rst_n),
    .line_one(line_one), .line_zero(line_zero),
    .loop_one(loop_one), .loop_zero(loop_zero),
    .self_test_n(self_test_n), .slow_sel(slow_sel),
    .dec_en(dec_en), .match_b9(match_b9), .match_b10(match_b10),
    .word_out(word_out), .word_valid(word_valid)
  );

  always @(negedge clk) begin
    if (rst_n && word_valid) begin
      vhigh++;
      if (!prev_v) vrise++;
      lastw = word_out;
    end
    prev_v = rst_n && word_valid;
  end

  // fields: word[35:4], dec_en[3], match_b9[2], match_b10[1], accept[0]
  localparam logic [35:0] VEC [0:7] = '{
    36'h0000_0001_1, 36'h8000_0300_F, 36'h8000_0100_E, 36'h0000_0200_B,
    36'hFFFF_FCFF_9, 36'hFFFF_FFFF_8, 36'hA5A5_5A5A_1, 36'h1234_5678_B
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] lvl, input int n, input int spb);
    if (use_loop) {loop_one, loop_zero} = lvl;
    else          {line_one, line_zero} = lvl;
    repeat (n * spb) @(negedge clk);
  endtask

  // kind: 0 normal, 1 no idle after bit `at`, 2 illegal state after bit `at`, 3 short glitch after bit `at`
  task automatic send(input logic [31:0] w, input int nbits, input int spb, input int kind, input int at);
    drive(2'b00, 25, spb);
    for (int i = 0; i < nbits; i++) begin
      drive(w[i] ? 2'b10 : 2'b01, 5, spb);
      if (kind == 1 && i == at) continue;
      if (kind == 2 && i == at) drive(2'b11, 5, spb);
      else if (kind == 3 && i == at) begin
        drive(2'b00, 1, spb); drive(2'b10, 2, spb); drive(2'b00, 2, spb);
      end else drive(2'b00, 5, spb);
    end
    drive(2'b00, 30, spb);
  endtask

  task automatic expect_word(input string req, input logic [31:0] w, input bit acc, input int v0, input logic [31:0] w0);
    chk(vrise == v0 + (acc ? 1 : 0), req, 32'(vrise), 32'(v0 + (acc ? 1 : 0)));
    if (acc) chk(lastw == w, req, lastw, w);
    else     chk(word_out == w0, req, word_out, w0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v0;
    logic [31:0] w0;
    repeat (5) @(negedge clk);
    chk(word_valid == 1'b0, "R11 valid in reset", 32'(word_valid), 32'd0);
    chk(word_out == '0, "R11 word in reset", word_out, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(word_out == '0 && !word_valid, "R11 after release", word_out, 32'd0);

    // table: R1 R3 R4
    for (int k = 0; k < 8; k++) begin
      dec_en = VEC[k][3]; match_b9 = VEC[k][2]; match_b10 = VEC[k][1];
      v0 = vrise; w0 = word_out;
      send(VEC[k][35:4], 32, 10, 0, 0);
      expect_word(VEC[k][3] ? "R3 selector filter" : "R4 R1 unfiltered", VEC[k][35:4], VEC[k][0], v0, w0);
    end
    dec_en = 1'b0;

    // R8 missing idle between bits
    v0 = vrise; w0 = word_out;
    send(32'h0000_0008, 32, 10, 1, 3);
    expect_word("R8 missing idle", 32'h0000_0008, 1'b0, v0, w0);

    // R7 both indications active
    v0 = vrise; w0 = word_out;
    send(32'h0F0F_0F0F, 32, 10, 2, 10);
    expect_word("R7 illegal state", 32'h0F0F_0F0F, 1'b0, v0, w0);

    // R6 two-sample glitch ignored
    v0 = vrise;
    send(32'h0000_0000, 32, 10, 3, 5);
    expect_word("R6 short glitch", 32'h0000_0000, 1'b1, v0, 32'h0);

    // R9 partial word cut by gap, then full word
    v0 = vrise;
    send(32'h0000_03FF, 10, 10, 0, 0);
    send(32'h0000_0400, 32, 10, 0, 0);
    expect_word("R9 partial discarded", 32'h0000_0400, 1'b1, v0, 32'h0);

    // R2 loopback selected, line held illegal
    {line_one, line_zero} = 2'b11;
    self_test_n = 1'b0; use_loop = 1'b1;
    v0 = vrise;
    send(32'hC3C3_3C3C, 32, 10, 0, 0);
    expect_word("R2 loopback used", 32'hC3C3_3C3C, 1'b1, v0, 32'h0);
    // R2 line selected: loop activity ignored
    {line_one, line_zero} = 2'b00;
    self_test_n = 1'b1;
    v0 = vrise; w0 = word_out;
    send(32'h5555_AAAA, 32, 10, 0, 0);
    expect_word("R2 loop ignored", 32'h5555_AAAA, 1'b0, v0, w0);
    use_loop = 1'b0;
    {loop_one, loop_zero} = 2'b11;
    v0 = vrise;
    send(32'h600D_F00D, 32, 10, 0, 0);
    expect_word("R2 line used", 32'h600D_F00D, 1'b1, v0, 32'h0);
    {loop_one, loop_zero} = 2'b00;

    // R5 slow divider
    slow_sel = 1'b1;
    v0 = vrise;
    send(32'h8421_1248, 32, 80, 0, 0);
    expect_word("R5 slow rate", 32'h8421_1248, 1'b1, v0, 32'h0);
    v0 = vrise; w0 = word_out;
    send(32'h1111_2222, 32, 10, 0, 0);
    expect_word("R5 fast word at slow rate", 32'h1111_2222, 1'b0, v0, w0);
    slow_sel = 1'b0;

    // R10 single-clock strobe over the whole run
    chk(vhigh == vrise, "R10 strobe width", 32'(vhigh), 32'(vrise));

    // R11 reset mid-word clears partial word and output
    drive(2'b00, 25, 10);
    for (int i = 0; i < 12; i++) begin
      drive(2'b10, 5, 10); drive(2'b00, 5, 10);
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(word_out == '0 && !word_valid, "R11 mid-word reset", word_out, 32'd0);
    rst_n = 1'b1;
    v0 = vrise;
    send(32'h0BAD_CAFE, 32, 10, 0, 0);
    expect_word("R11 clean restart", 32'h0BAD_CAFE, 1'b1, v0, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule